// File: doc/BRIEF.md
# Indexed complex multiply-accumulate with rotation

This unit performs a rotated complex multiply-accumulate across a wide vector in one registered step. Three vectors enter together: a multiplicand, a multiplier source and an accumulator. Each vector is a row of signed complex numbers. Every complex number takes two adjacent elements, with the real part in the even element and the imaginary part in the odd element. A mode input sets the element width to 16 or 32 bits. The vector length is a parameter and must be a multiple of 128 bits.

Within each 128-bit slice, an index input picks one complex number from the multiplier source. That number is broadcast to every pair in the same slice. A 2-bit rotation code (0, 90, 180 or 270 degrees) decides two things: which component of each multiplicand pair is used, and whether each output lane adds or subtracts its product. Two passes with the same operands and rotations 90 degrees apart give a full complex multiply-add. For 0 then 90 the unit adds the product; for 180 then 270 it subtracts it.

A single-cycle `in_valid` pulse captures all the operands. The complete result vector and `out_valid` appear on the next clock.

Top module: `cplx_idx_mac`

## Requirements
- R1: Pair p of a vector is elements 2p (real) and 2p+1 (imaginary). The multiplicand element used for pair p is the real element when rot[0] is 0 (codes 00=0 deg, 10=180 deg) and the imaginary element when rot[0] is 1 (01=90 deg, 11=270 deg).
- R2: The real output lane multiplies by multiplier element 2s+rot[0]. The imaginary output lane multiplies by element 2s+(1-rot[0]).
- R3: The real lane subtracts its product from the accumulator when rot[0] differs from rot[1], and adds it otherwise. The imaginary lane subtracts when rot[1] is 1, and adds otherwise.
- R4: With mode 0 (16-bit elements, four pairs per 128-bit slice), s = 4*floor(p/4) + idx, and idx may take any value from 0 to 3.
- R5: With mode 1 (32-bit elements, two pairs per 128-bit slice), s = 2*floor(p/2) + idx[0], and idx[1] has no effect.
- R6: All multiplies are signed. Every result element is truncated to the element width, wrapping modulo 2^esize with no saturation.
- R7: In the clock after an edge that samples `in_valid` high, `out_valid` is high and `result` holds the value computed from the operands sampled at that edge. In the clock after an edge that samples `in_valid` low, `out_valid` is low.
- R8: An edge that samples `rst_n` low clears `out_valid` and `result` to zero (synchronous, active low).
- R9: While `in_valid` is low, `result` holds its value, whatever the other inputs do.
- R10: Two operations with the same multiplicand and multiplier, the second using the first's result as accumulator, give accumulator plus the complex product for rotations 0 then 90. For rotations 180 then 270 they give accumulator minus the complex product, element-wise modulo 2^esize.
- R11: An all-zero multiplicand or an all-zero multiplier returns the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Captures operands and starts an operation |
| mode | input | 1 | Element width: 0 = 16-bit, 1 = 32-bit |
| rot | input | 2 | Rotation code: 00=0, 01=90, 10=180, 11=270 degrees |
| idx | input | 2 | Pair index of the multiplier within each 128-bit slice |
| src_a | input | VLEN | Multiplicand vector |
| src_b | input | VLEN | Multiplier source vector |
| src_c | input | VLEN | Accumulator vector |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| result | output | VLEN | Accumulated result vector |

## Verification
The bench goes through every rotation and index in both widths. A unit that swapped the component choice or a sign would corrupt whole lanes for just those codes. Slice-local broadcasting is exercised with different data in every slice, so a unit that took its multiplier from the first slice only, or ignored idx[1] at 16 bits, would fail in the upper slices. Extreme operands (most negative times most negative) expose saturation or widening in place of wrap-around. Paired rotations check that the two half-products combine into the true complex product, and idle cycles with churning inputs expose a result register that fails to hold.

// File: rtl/cplx_idx_mac.sv
module cplx_idx_mac #(
  parameter int VLEN = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            mode,
  input  logic [1:0]      rot,
  input  logic [1:0]      idx,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  input  logic [VLEN-1:0] src_c,
  output logic            out_valid,
  output logic [VLEN-1:0] result
);
  localparam int NP16 = VLEN / 32;
  localparam int NP32 = VLEN / 64;

  logic [VLEN-1:0] res16, res32, nxt;
  logic sub_re, sub_im;

  assign sub_re = rot[0] ^ rot[1];
  assign sub_im = rot[1];

  for (genvar p = 0; p < NP16; p++) begin : g_h
    localparam int BASE = p - (p % 4);
    logic signed [15:0] a_el, m_re, m_im, pr_re, pr_im;
    logic [31:0] b_pair;
    logic [15:0] c_re, c_im;
    assign a_el   = rot[0] ? src_a[(2*p+1)*16 +: 16] : src_a[(2*p)*16 +: 16];
    assign b_pair = src_b[(BASE + int'(idx))*32 +: 32];
    assign m_re   = rot[0] ? b_pair[31:16] : b_pair[15:0];
    assign m_im   = rot[0] ? b_pair[15:0]  : b_pair[31:16];
    assign pr_re  = a_el * m_re;
    assign pr_im  = a_el * m_im;
    assign c_re   = src_c[(2*p)*16 +: 16];
    assign c_im   = src_c[(2*p+1)*16 +: 16];
    assign res16[(2*p)*16 +: 16]   = sub_re ? c_re - pr_re : c_re + pr_re;
    assign res16[(2*p+1)*16 +: 16] = sub_im ? c_im - pr_im : c_im + pr_im;
  end

  for (genvar p = 0; p < NP32; p++) begin : g_w
    localparam int BASE = p - (p % 2);
    logic signed [31:0] a_el, m_re, m_im, pr_re, pr_im;
    logic [63:0] b_pair;
    logic [31:0] c_re, c_im;
    assign a_el   = rot[0] ? src_a[(2*p+1)*32 +: 32] : src_a[(2*p)*32 +: 32];
    assign b_pair = src_b[(BASE + int'(idx[0]))*64 +: 64];
    assign m_re   = rot[0] ? b_pair[63:32] : b_pair[31:0];
    assign m_im   = rot[0] ? b_pair[31:0]  : b_pair[63:32];
    assign pr_re  = a_el * m_re;
    assign pr_im  = a_el * m_im;
    assign c_re   = src_c[(2*p)*32 +: 32];
    assign c_im   = src_c[(2*p+1)*32 +: 32];
    assign res32[(2*p)*32 +: 32]   = sub_re ? c_re - pr_re : c_re + pr_re;
    assign res32[(2*p+1)*32 +: 32] = sub_im ? c_im - pr_im : c_im + pr_im;
  end

  assign nxt = mode ? res32 : res16;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  p_valid_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  p_reset_clear_r8: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && result == '0));

  p_zero_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_a == '0) |=> result == $past(src_c));

  p_zero_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_b == '0) |=> result == $past(src_c));
endmodule

// File: tb/cplx_idx_mac_test.sv
`timescale 1ns/1ps
module cplx_idx_mac_test;
  localparam int VLEN = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic mode = 1'b0;
  logic [1:0] rot = 2'd0, idx = 2'd0;
  logic [VLEN-1:0] va = '0, vb = '0, vc = '0;
  logic out_valid;
  logic [VLEN-1:0] result;

  int n_chk = 0, n_fail = 0;
  bit started = 0, done = 0;
  string cur_tag = "R8";
  logic m_v = 1'b0;
  logic [VLEN-1:0] m_r = '0;

  always #2.5 clk = ~clk;

  cplx_idx_mac #(.VLEN(VLEN)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .rot(rot), .idx(idx),
    .src_a(va), .src_b(vb), .src_c(vc), .out_valid(out_valid), .result(result));

  function automatic longint get_el(logic [VLEN-1:0] v, int e, int es);
    logic [VLEN-1:0] sh = v >> (e*es);
    if (es == 16) return longint'($signed(sh[15:0]));
    return longint'($signed(sh[31:0]));
  endfunction

  function automatic logic [VLEN-1:0] put_el(logic [VLEN-1:0] v, int e, int es, longint val);
    logic [VLEN-1:0] mask = (es == 16) ? VLEN'(16'hffff) : VLEN'(32'hffffffff);
    logic [VLEN-1:0] x = VLEN'(val) & mask;
    return (v & ~(mask << (e*es))) | (x << (e*es));
  endfunction

  function automatic logic [VLEN-1:0] ref_op(logic md, logic [1:0] r, logic [1:0] ix,
                                             logic [VLEN-1:0] a, b, c);
    int es = md ? 32 : 16;
    int np = VLEN / (2*es);
    int pps = 128 / (2*es);
    int k = md ? int'(ix[0]) : int'(ix);
    logic [VLEN-1:0] o = '0;
    for (int p = 0; p < np; p++) begin
      int s = (p / pps) * pps + k;
      longint ar = get_el(a, 2*p, es), ai = get_el(a, 2*p+1, es);
      longint br = get_el(b, 2*s, es), bi = get_el(b, 2*s+1, es);
      longint re = get_el(c, 2*p, es), im = get_el(c, 2*p+1, es);
      case (r)
        2'd0: begin re = re + ar*br; im = im + ar*bi; end
        2'd1: begin re = re - ai*bi; im = im + ai*br; end
        2'd2: begin re = re - ar*br; im = im - ar*bi; end
        default: begin re = re + ai*bi; im = im - ai*br; end
      endcase
      o = put_el(o, 2*p, es, re);
      o = put_el(o, 2*p+1, es, im);
    end
    return o;
  endfunction

  function automatic logic [VLEN-1:0] full_cmul(logic md, logic [1:0] ix,
                                                logic [VLEN-1:0] a, b, c, bit neg);
    int es = md ? 32 : 16;
    int pps = 128 / (2*es);
    logic [VLEN-1:0] o = '0;
    for (int p = 0; p < VLEN/(2*es); p++) begin
      int s = (p / pps) * pps + (md ? int'(ix[0]) : int'(ix));
      longint ar = get_el(a, 2*p, es), ai = get_el(a, 2*p+1, es);
      longint br = get_el(b, 2*s, es), bi = get_el(b, 2*s+1, es);
      longint pre = ar*br - ai*bi, pim = ar*bi + ai*br;
      if (neg) begin pre = -pre; pim = -pim; end
      o = put_el(o, 2*p, es, get_el(c, 2*p, es) + pre);
      o = put_el(o, 2*p+1, es, get_el(c, 2*p+1, es) + pim);
    end
    return o;
  endfunction

  task automatic chk(string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      m_v <= 1'b0;
      m_r <= '0;
    end else begin
      m_v <= in_valid;
      if (in_valid) m_r <= ref_op(mode, rot, idx, va, vb, vc);
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R7", VLEN'(out_valid), VLEN'(m_v));
      chk(cur_tag, result, m_r);
    end
  end

  task automatic do_op(logic md, logic [1:0] r, logic [1:0] ix,
                       logic [VLEN-1:0] a, b, c, string tag);
    @(negedge clk);
    mode = md; rot = r; idx = ix; va = a; vb = b; vc = c;
    cur_tag = tag; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] a, b, c, r1, held;
    repeat (3) @(negedge clk);
    chk("R8", VLEN'(out_valid), '0);
    chk("R8", result, '0);
    rst_n = 1'b1;

    // R2 R3 R4 R5: sweep rotations and indices in both widths
    for (int md = 0; md < 2; md++)
      for (int r = 0; r < 4; r++)
        for (int ix = 0; ix < 4; ix++) begin
          a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
          do_op(md[0], r[1:0], ix[1:0], a, b, c, md ? "R5/R2/R3" : "R4/R2/R3");
        end

    // R5: idx[1] has no effect in 32-bit mode
    a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
    do_op(1'b1, 2'd1, 2'd1, a, b, c, "R5");
    r1 = result;
    do_op(1'b1, 2'd1, 2'd3, a, b, c, "R5");
    chk("R5", result, r1);

    // R1: only real multiplicand parts nonzero, rotation 90 leaves accumulator
    a = rnd_vec();
    for (int e = 0; e < VLEN/16; e++) if (e % 2 == 1) a[e*16 +: 16] = '0;
    b = rnd_vec(); c = rnd_vec();
    do_op(1'b0, 2'd1, 2'd2, a, b, c, "R1");
    chk("R1", result, c);
    do_op(1'b0, 2'd3, 2'd0, a, b, c, "R1");
    chk("R1", result, c);

    // R6: extreme operands wrap
    a = {(VLEN/16){16'h8000}}; b = {(VLEN/16){16'h8000}}; c = {(VLEN/16){16'h7fff}};
    do_op(1'b0, 2'd0, 2'd3, a, b, c, "R6");
    chk("R6", result, {(VLEN/16){16'h7fff}});
    a = {(VLEN/32){32'h7fffffff}}; b = {(VLEN/32){32'h7fffffff}}; c = {(VLEN/32){32'h7fffffff}};
    do_op(1'b1, 2'd0, 2'd0, a, b, c, "R6");
    chk("R6", result, {(VLEN/32){32'h80000000}});

    // R11: zero multiplicand / zero multiplier
    b = rnd_vec(); c = rnd_vec();
    do_op(1'b0, 2'd2, 2'd1, '0, b, c, "R11");
    chk("R11", result, c);
    a = rnd_vec();
    do_op(1'b1, 2'd3, 2'd0, a, '0, c, "R11");
    chk("R11", result, c);

    // R10: rotations 90 degrees apart form a full complex product
    for (int md = 0; md < 2; md++)
      for (int ng = 0; ng < 2; ng++) begin
        a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
        do_op(md[0], ng ? 2'd2 : 2'd0, 2'd1, a, b, c, "R10");
        r1 = result;
        do_op(md[0], ng ? 2'd3 : 2'd1, 2'd1, a, b, r1, "R10");
        chk("R10", result, full_cmul(md[0], 2'd1, a, b, c, ng[0]));
      end

    // R9: result holds while inputs change with in_valid low
    held = result;
    cur_tag = "R9";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      va = rnd_vec(); vb = rnd_vec(); vc = rnd_vec(); rot = rot + 2'd1; mode = ~mode;
    end
    @(negedge clk);
    chk("R9", result, held);
    chk("R7", VLEN'(out_valid), '0);

    // R8: reset mid-stream
    do_op(1'b0, 2'd0, 2'd0, rnd_vec(), rnd_vec(), rnd_vec(), "R7");
    @(negedge clk);
    rst_n = 1'b0;
    cur_tag = "R8";
    @(negedge clk);
    chk("R8", result, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule